// File: doc/BRIEF.md
# SIMT Warp Divergence Mask Controller

This block owns the program counter and the active-lane mask of one warp, a group of lanes that share a single program counter. Each cycle in which it issues, it receives a description of the instruction at the current PC: plain, branch or exit. For a branch it also receives a per-lane vote (`taken_i`, bit l = 1 means lane l takes the branch), the branch target and the reconvergence address, which is the immediate post-dominator of the branch. The fall-through address is always PC + 1. When the active lanes agree, the warp follows the chosen path with its mask unchanged. When they disagree, the block records on a small stack the mask to restore and the deferred not-taken path. It then runs the taken lanes first, then the not-taken lanes, and brings back the earlier mask once the PC reaches the reconvergence address.

Loop back-edges use the same mechanism. Lanes whose loop has finished vote not-taken and drop out of the mask on each pass. The loop keeps running until the last lane leaves, and no extra stack space is used per iteration. Lanes that are absent at launch, and lanes that have executed an exit, are never enabled again. An issue counter lets the surrounding logic measure the serialized cost of a divergent region.

Top module: `simt_div_ctrl`

## Requirements
- R1: A one-cycle `start_i` loads `pc_o` = `start_pc_i` and `mask_o` = `lane_en_i`, and clears the issue count and the overflow flag. After reset the block is idle: mask 0, `issue_o` 0, `done_o` 0, `ovf_o` 0.
- R2: Every issued instruction adds one to `cyc_o`. A plain instruction moves the PC to PC + 1. For a divergent region, the count equals the sum of the instructions executed on each path plus those outside the region.
- R3: When all active lanes vote the same way, nothing is pushed and the mask is unchanged. The PC goes to the target if all voted 1, or to PC + 1 if all voted 0.
- R4: When active lanes disagree, the warp jumps to the target with mask = active & taken. Afterwards it runs the fall-through path with mask = active & ~taken.
- R5: While the stack holds entries and the PC equals the current reconvergence address, the next cycle is a non-issuing cycle that restores the saved path or mask. After both paths, the mask from before the split is back at the reconvergence address.
- R6: A branch whose body sits on the not-taken side and whose target is the reconvergence address still splits. The body runs only for the not-taken lanes, and all lanes rejoin at the target.
- R7: At a loop back-edge (target = loop head, reconvergence = PC + 1), lanes voting 0 leave the mask on each pass. The loop repeats until no active lane votes 1, and then the full entry mask resumes at PC + 1.
- R8: A lane whose `lane_en_i` bit was 0 at launch never appears in `mask_o`, whatever it votes.
- R9: An exit removes the active lanes for good. Saved masks restored later exclude them. When no lane remains, `done_o` goes to 1 and the mask stays 0.
- R10: A split needing more stack entries than are free sets the sticky `ovf_o`. The PC, the mask and the stack are then held unchanged. Without such a split, `ovf_o` stays 0.
- R11: `issue_o` is 0 while idle, during restore cycles and once done. A launch therefore lasts issued instructions plus restore cycles until `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Launch pulse |
| start_pc_i | input | PCW | First PC of the launch |
| lane_en_i | input | LANES | Lanes present in the warp |
| is_br_i | input | 1 | Instruction at `pc_o` is a conditional branch |
| is_exit_i | input | 1 | Instruction at `pc_o` is an exit |
| taken_i | input | LANES | Per-lane branch vote |
| target_i | input | PCW | Branch target |
| reconv_i | input | PCW | Reconvergence address of the branch |
| issue_o | output | 1 | Instruction at `pc_o` executes this cycle |
| pc_o | output | PCW | Current PC |
| mask_o | output | LANES | Current active-lane mask |
| done_o | output | 1 | All lanes have exited |
| ovf_o | output | 1 | Sticky stack overflow flag |
| cyc_o | output | CW | Issued-instruction count since launch |

## Verification
The bench runs one divergent lane against thirty-one lanes. A design that weighted path cost by lane count would report fewer issued cycles than the two full path lengths. It runs loops with unequal per-lane trip counts: a design that stopped at an average count, or pushed one entry per pass, would show a wrong last-pass mask or cycle count. It runs a partially filled warp whose absent lanes vote differently from the present ones. That must stay unanimous, and a design that let absent lanes vote would split and restore them. It also exits one subset inside a split, where a design that restored the saved mask blindly would bring dead lanes back. Finally it nests branches past the stack depth, where a design that kept going would corrupt the stack instead of holding and flagging.

// File: rtl/simt_div_pkg.sv
package simt_div_pkg;

    // Outcome of a per-lane vote against the active mask
    typedef enum logic [1:0] {
        BR_NONE  = 2'd0,
        BR_TAKEN = 2'd1,
        BR_FALL  = 2'd2,
        BR_SPLIT = 2'd3
    } br_cls_e;

endpackage

// File: rtl/div_vote.sv
module div_vote
    import simt_div_pkg::*;
#(
    parameter int LANES = 32
) (
    input  logic [LANES-1:0] mask_i,
    input  logic [LANES-1:0] taken_i,
    output br_cls_e          cls_o,
    output logic [LANES-1:0] t_o,
    output logic [LANES-1:0] nt_o
);

    always_comb begin
        t_o  = taken_i & mask_i;
        nt_o = mask_i & ~taken_i;
        if (mask_i == '0) begin
            cls_o = BR_NONE;
        end else if (nt_o == '0) begin
            cls_o = BR_TAKEN;
        end else if (t_o == '0) begin
            cls_o = BR_FALL;
        end else begin
            cls_o = BR_SPLIT;
        end
    end

endmodule

// File: rtl/div_stack.sv
module div_stack #(
    parameter int EW    = 64,
    parameter int DEPTH = 8,
    localparam int DW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          push_a_i,
    input  logic          push_b_i,
    input  logic [EW-1:0] ent_a_i,
    input  logic [EW-1:0] ent_b_i,
    input  logic          pop_i,
    output logic [EW-1:0] top_o,
    output logic [DW-1:0] depth_o
);

    typedef struct packed {
        logic [DEPTH-1:0][EW-1:0] mem;
        logic [DW-1:0]            depth;
    } stk_t;

    stk_t stk_q, stk_d;

    always_comb begin
        int ia;
        int ib;
        stk_d = stk_q;
        ia    = int'(stk_q.depth);
        ib    = ia + (push_a_i ? 1 : 0);
        if (clr_i) begin
            stk_d.depth = '0;
        end else if (pop_i && stk_q.depth != '0) begin
            stk_d.depth = stk_q.depth - DW'(1);
        end else begin
            for (int k = 0; k < DEPTH; k++) begin
                if (push_a_i && k == ia) stk_d.mem[k] = ent_a_i;
                if (push_b_i && k == ib) stk_d.mem[k] = ent_b_i;
            end
            stk_d.depth = stk_q.depth + DW'(push_a_i) + DW'(push_b_i);
        end
    end

    always_comb begin
        top_o = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (k + 1 == int'(stk_q.depth)) top_o = stk_q.mem[k];
        end
    end

    assign depth_o = stk_q.depth;

    always_ff @(posedge clk) begin
        if (!rst_n) stk_q <= '0;
        else        stk_q <= stk_d;
    end

    // R10: the stack never holds more entries than it has slots
    a_r10_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(stk_q.depth) <= DEPTH);

    // R10: the controller never asks for a push that does not fit
    a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !pop_i) |->
        (int'(stk_q.depth) + (push_a_i ? 1 : 0) + (push_b_i ? 1 : 0) <= DEPTH));

endmodule

// File: rtl/simt_div_ctrl.sv
module simt_div_ctrl
    import simt_div_pkg::*;
#(
    parameter int LANES = 32,
    parameter int PCW   = 16,
    parameter int DEPTH = 8,
    parameter int CW    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [PCW-1:0]   start_pc_i,
    input  logic [LANES-1:0] lane_en_i,
    input  logic             is_br_i,
    input  logic             is_exit_i,
    input  logic [LANES-1:0] taken_i,
    input  logic [PCW-1:0]   target_i,
    input  logic [PCW-1:0]   reconv_i,
    output logic             issue_o,
    output logic [PCW-1:0]   pc_o,
    output logic [LANES-1:0] mask_o,
    output logic             done_o,
    output logic             ovf_o,
    output logic [CW-1:0]    cyc_o
);

    localparam int EW = 2 * PCW + LANES;
    localparam int DW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PCW-1:0]   rpc;
        logic [PCW-1:0]   npc;
        logic [LANES-1:0] mask;
    } ent_t;

    typedef struct packed {
        logic [PCW-1:0]   pc;
        logic [PCW-1:0]   rpc;
        logic [LANES-1:0] mask;
        logic [LANES-1:0] alive;
        logic             active;
        logic             launched;
        logic             ovf;
        logic [CW-1:0]    cyc;
    } st_t;

    st_t              st_q, st_d;
    logic [DW-1:0]    depth;
    logic [EW-1:0]    top_raw;
    ent_t             top_e;
    ent_t             ent_a, ent_b;
    logic             push_a, push_b, pop, clr;
    br_cls_e          cls;
    logic [LANES-1:0] t_m, nt_m;
    logic             issue, pop_now, need_r, need_n, fits, ovf_evt;
    logic [PCW-1:0]   fall_pc;

    assign top_e = ent_t'(top_raw);

    div_vote #(.LANES(LANES)) u_vote (
        .mask_i  (st_q.mask),
        .taken_i (taken_i),
        .cls_o   (cls),
        .t_o     (t_m),
        .nt_o    (nt_m)
    );

    div_stack #(.EW(EW), .DEPTH(DEPTH)) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (clr),
        .push_a_i (push_a),
        .push_b_i (push_b),
        .ent_a_i  (ent_a),
        .ent_b_i  (ent_b),
        .pop_i    (pop),
        .top_o    (top_raw),
        .depth_o  (depth)
    );

    // A restore is due when the path reached its merge point or ran out of lanes
    assign pop_now = st_q.active && depth != '0 &&
                     (st_q.mask == '0 || st_q.pc == st_q.rpc);
    assign issue   = st_q.active && st_q.mask != '0 && !pop_now;

    always_comb begin
        st_d    = st_q;
        push_a  = 1'b0;
        push_b  = 1'b0;
        pop     = 1'b0;
        clr     = 1'b0;
        ovf_evt = 1'b0;
        fall_pc = st_q.pc + PCW'(1);
        // restore entry only when this region merges somewhere new
        need_r  = (reconv_i != st_q.rpc);
        // deferred path only when the fall-through is not the merge point
        need_n  = (fall_pc != reconv_i);
        fits    = (int'(depth) + (need_r ? 1 : 0) + (need_n ? 1 : 0)) <= DEPTH;
        ent_a   = '{rpc: st_q.rpc, npc: reconv_i, mask: st_q.mask};
        ent_b   = '{rpc: reconv_i, npc: fall_pc, mask: nt_m};

        if (start_i) begin
            st_d.pc       = start_pc_i;
            st_d.rpc      = '1;
            st_d.mask     = lane_en_i;
            st_d.alive    = lane_en_i;
            st_d.active   = (lane_en_i != '0);
            st_d.launched = 1'b1;
            st_d.ovf      = 1'b0;
            st_d.cyc      = '0;
            clr           = 1'b1;
        end else if (pop_now) begin
            pop       = 1'b1;
            st_d.pc   = top_e.npc;
            st_d.rpc  = top_e.rpc;
            st_d.mask = top_e.mask & st_q.alive;
        end else if (issue) begin
            st_d.cyc = st_q.cyc + CW'(1);
            if (is_exit_i) begin
                st_d.alive = st_q.alive & ~st_q.mask;
                st_d.mask  = '0;
                if ((st_q.alive & ~st_q.mask) == '0) st_d.active = 1'b0;
            end else if (is_br_i) begin
                case (cls)
                    BR_TAKEN: st_d.pc = target_i;
                    BR_FALL:  st_d.pc = fall_pc;
                    BR_SPLIT: begin
                        if (!fits) begin
                            ovf_evt  = 1'b1;
                            st_d.ovf = 1'b1;
                        end else begin
                            push_a    = need_r;
                            push_b    = need_n;
                            st_d.pc   = target_i;
                            st_d.mask = t_m;
                            st_d.rpc  = reconv_i;
                        end
                    end
                    default: st_d.pc = fall_pc;
                endcase
            end else begin
                st_d.pc = fall_pc;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign issue_o = issue;
    assign pc_o    = st_q.pc;
    assign mask_o  = st_q.mask;
    assign done_o  = st_q.launched && !st_q.active;
    assign ovf_o   = st_q.ovf;
    assign cyc_o   = st_q.cyc;

    // R3: a unanimous vote leaves the mask alone
    a_r3_unanimous_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && is_br_i && !is_exit_i && !start_i &&
         (cls == BR_TAKEN || cls == BR_FALL))
        |=> (mask_o == $past(mask_o)));

    // R4: a split continues at the target with only the taken lanes
    a_r4_split_taken_first: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && is_br_i && !is_exit_i && !start_i && cls == BR_SPLIT && fits)
        |=> (mask_o == $past(taken_i & mask_o) && pc_o == $past(target_i)));

    // R8, R9: no lane outside the live set is ever active
    a_r8_live_lanes_only: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mask & ~st_q.alive) == '0);

    // R9: a finished warp has no active lane and issues nothing
    a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (mask_o == '0 && !issue_o));

    // R10: an overflowing split freezes the warp and raises the flag
    a_r10_ovf_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_evt && !start_i)
        |=> (ovf_o && pc_o == $past(pc_o) && mask_o == $past(mask_o)));

endmodule

// File: tb/sim_simt_div_ctrl.sv
module sim_simt_div_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int LANES      = 32;
    localparam int PCW        = 8;
    localparam int DEPTH      = 4;
    localparam int CW         = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [PCW-1:0]   start_pc_i = '0;
    logic [LANES-1:0] lane_en_i = '0;
    logic             is_br_i, is_exit_i;
    logic [LANES-1:0] taken_i;
    logic [PCW-1:0]   target_i, reconv_i;
    logic             issue_o, done_o, ovf_o;
    logic [PCW-1:0]   pc_o;
    logic [LANES-1:0] mask_o;
    logic [CW-1:0]    cyc_o;

    int               n_checks = 0;
    int               n_fail   = 0;
    int               wd       = 0;

    int               sel  = 0;
    logic [31:0]      vote = '0;
    int               tmod = 1;
    logic [7:0]       cnt [LANES];
    logic [31:0]      loop_tk;
    logic [31:0]      seen [16];
    int               busy;

    always #(CLK_PERIOD / 2) clk = ~clk;

    simt_div_ctrl #(.LANES(LANES), .PCW(PCW), .DEPTH(DEPTH), .CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_pc_i(start_pc_i),
        .lane_en_i(lane_en_i), .is_br_i(is_br_i), .is_exit_i(is_exit_i),
        .taken_i(taken_i), .target_i(target_i), .reconv_i(reconv_i),
        .issue_o(issue_o), .pc_o(pc_o), .mask_o(mask_o), .done_o(done_o),
        .ovf_o(ovf_o), .cyc_o(cyc_o)
    );

    // per-lane loop progress: lane l runs (l % tmod) + 1 passes
    always_ff @(posedge clk) begin
        for (int l = 0; l < LANES; l++) begin
            if (start_i) cnt[l] <= '0;
            else if (issue_o && sel == 2 && pc_o == 8'd2 && mask_o[l]) cnt[l] <= cnt[l] + 8'd1;
        end
    end

    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            loop_tk[l] = (tmod > 0) && (int'(cnt[l]) + 1 < (l % tmod) + 1);
        end
    end

    // instruction source: small programs indexed by sel
    always_comb begin
        is_br_i = 1'b0; is_exit_i = 1'b0; taken_i = '0; target_i = '0; reconv_i = '0;
        case (sel)
            0: case (pc_o)
                   8'd1: begin is_br_i = 1'b1; taken_i = vote; target_i = 8'd4; reconv_i = 8'd6; end
                   8'd3: begin is_br_i = 1'b1; taken_i = '1; target_i = 8'd6; reconv_i = 8'd7; end
                   8'd7: is_exit_i = 1'b1;
                   default: ;
               endcase
            1: case (pc_o)
                   8'd1: begin is_br_i = 1'b1; taken_i = vote; target_i = 8'd3; reconv_i = 8'd3; end
                   8'd4: is_exit_i = 1'b1;
                   default: ;
               endcase
            2: case (pc_o)
                   8'd2: begin is_br_i = 1'b1; taken_i = loop_tk; target_i = 8'd1; reconv_i = 8'd3; end
                   8'd4: is_exit_i = 1'b1;
                   default: ;
               endcase
            3: case (pc_o)
                   8'd0: begin is_br_i = 1'b1; taken_i = vote; target_i = 8'd3; reconv_i = 8'd4; end
                   8'd2, 8'd5: is_exit_i = 1'b1;
                   default: ;
               endcase
            4: case (pc_o)
                   8'd0: begin is_br_i = 1'b1; taken_i = 32'h0000FFFF; target_i = 8'd1; reconv_i = 8'd10; end
                   8'd1: begin is_br_i = 1'b1; taken_i = 32'h000000FF; target_i = 8'd2; reconv_i = 8'd9; end
                   8'd2: begin is_br_i = 1'b1; taken_i = 32'h0000000F; target_i = 8'd3; reconv_i = 8'd8; end
                   default: ;
               endcase
            default: ;
        endcase
    end

    typedef struct packed {
        logic [3:0]  sel;
        logic [31:0] vote;
        logic [31:0] en;
        logic [7:0]  tmod;
        logic [7:0]  cyc;
        logic [7:0]  busy;
        logic [31:0] ma;
        logic [31:0] mb;
        logic [31:0] mc;
    } row_t;

    // probe masks: last mask seen at probe PCs a/b/c (0 = never issued there)
    localparam row_t TBL [13] = '{
        '{4'd0, 32'h0000FFFF, 32'hFFFFFFFF, 8'd1, 8'd8,  8'd10, 32'h0000FFFF, 32'hFFFF0000, 32'hFFFFFFFF},
        '{4'd0, 32'hFFFFFFFF, 32'hFFFFFFFF, 8'd1, 8'd6,  8'd6,  32'hFFFFFFFF, 32'h00000000, 32'hFFFFFFFF},
        '{4'd0, 32'h00000000, 32'hFFFFFFFF, 8'd1, 8'd6,  8'd6,  32'h00000000, 32'hFFFFFFFF, 32'hFFFFFFFF},
        '{4'd0, 32'h00000001, 32'hFFFFFFFF, 8'd1, 8'd8,  8'd10, 32'h00000001, 32'hFFFFFFFE, 32'hFFFFFFFF},
        '{4'd0, 32'hFFF00000, 32'h000FFFFF, 8'd1, 8'd6,  8'd6,  32'h00000000, 32'h000FFFFF, 32'h000FFFFF},
        '{4'd0, 32'h55555555, 32'h000FFFFF, 8'd1, 8'd8,  8'd10, 32'h00055555, 32'h000AAAAA, 32'h000FFFFF},
        '{4'd1, 32'hFFFF0000, 32'hFFFFFFFF, 8'd1, 8'd5,  8'd7,  32'h0000FFFF, 32'hFFFFFFFF, 32'hFFFFFFFF},
        '{4'd1, 32'hFFFFFFFF, 32'hFFFFFFFF, 8'd1, 8'd4,  8'd4,  32'h00000000, 32'hFFFFFFFF, 32'hFFFFFFFF},
        '{4'd2, 32'h00000000, 32'hFFFFFFFF, 8'd1, 8'd5,  8'd5,  32'hFFFFFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF},
        '{4'd2, 32'h00000000, 32'hFFFFFFFF, 8'd4, 8'd11, 8'd12, 32'h88888888, 32'hFFFFFFFF, 32'hFFFFFFFF},
        '{4'd2, 32'h00000000, 32'h77777777, 8'd4, 8'd9,  8'd10, 32'h44444444, 32'h77777777, 32'h77777777},
        '{4'd3, 32'h0F0F0F0F, 32'hFFFFFFFF, 8'd1, 8'd6,  8'd8,  32'h0F0F0F0F, 32'hF0F0F0F0, 32'h0F0F0F0F},
        '{4'd3, 32'h00000000, 32'hFFFFFFFF, 8'd1, 8'd3,  8'd3,  32'h00000000, 32'hFFFFFFFF, 32'h00000000}
    };

    function automatic int probe(input int s, input int which);
        int p [4][3] = '{'{4, 2, 6}, '{2, 3, 4}, '{1, 3, 0}, '{4, 1, 3}};
        return p[s][which];
    endfunction

    function automatic string rtag(input int i);
        case (i)
            0:          return "R4";
            1, 2, 7:    return "R3";
            3:          return "R5";
            4, 5, 10:   return "R8";
            6:          return "R6";
            8, 9:       return "R7";
            default:    return "R9";
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %08h expected %08h", tag, what, act, exp);
        end
    endtask

    task automatic launch(input int s, input logic [31:0] v, input logic [31:0] en, input int tm);
        @(negedge clk);
        sel = s; vote = v; tmod = tm;
        lane_en_i = en; start_pc_i = '0; start_i = 1'b1;
        for (int k = 0; k < 16; k++) seen[k] = '0;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic run_to_done();
        busy = 0;
        while (!done_o && busy < 300) begin
            if (issue_o) seen[pc_o[3:0]] = mask_o;
            busy++;
            @(negedge clk);
        end
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 100000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below %0d", wd, 100000);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk(mask_o == '0, "R1", "reset mask", mask_o, 32'h0);
        chk(!issue_o, "R11", "reset issue", {31'b0, issue_o}, 32'h0);
        chk(!done_o, "R1", "reset done", {31'b0, done_o}, 32'h0);
        chk(!ovf_o, "R1", "reset ovf", {31'b0, ovf_o}, 32'h0);

        // launch state of a partial warp
        launch(0, 32'h0000FFFF, 32'h000FFFFF, 1);
        chk(pc_o == 8'd0, "R1", "launch pc", {24'b0, pc_o}, 32'h0);
        chk(mask_o == 32'h000FFFFF, "R1", "launch mask", mask_o, 32'h000FFFFF);
        chk(cyc_o == '0, "R1", "launch count", {16'b0, cyc_o}, 32'h0);
        run_to_done();

        // vector table
        for (int i = 0; i < 13; i++) begin
            row_t r;
            r = TBL[i];
            launch(int'(r.sel), r.vote, r.en, int'(r.tmod));
            run_to_done();
            chk(done_o, "R9", "done", {31'b0, done_o}, 32'h1);
            chk(cyc_o == 16'(r.cyc), "R2", "issued count", {16'b0, cyc_o}, {24'b0, r.cyc});
            chk(busy == int'(r.busy), "R11", "launch length", busy, {24'b0, r.busy});
            chk(seen[probe(int'(r.sel), 0)] == r.ma, rtag(i), "path mask a", seen[probe(int'(r.sel), 0)], r.ma);
            chk(seen[probe(int'(r.sel), 1)] == r.mb, rtag(i), "path mask b", seen[probe(int'(r.sel), 1)], r.mb);
            chk(seen[probe(int'(r.sel), 2)] == r.mc, "R5", "reconverged mask", seen[probe(int'(r.sel), 2)], r.mc);
            chk(!ovf_o, "R10", "no overflow", {31'b0, ovf_o}, 32'h0);
            chk(mask_o == '0, "R9", "done mask", mask_o, 32'h0);
        end

        // nesting past the stack depth
        launch(4, 32'h0, 32'hFFFFFFFF, 1);
        repeat (6) @(negedge clk);
        chk(ovf_o, "R10", "overflow flag", {31'b0, ovf_o}, 32'h1);
        chk(pc_o == 8'd2, "R10", "held pc", {24'b0, pc_o}, 32'h2);
        chk(mask_o == 32'h000000FF, "R10", "held mask", mask_o, 32'h000000FF);
        launch(0, 32'h0000FFFF, 32'hFFFFFFFF, 1);
        chk(!ovf_o, "R1", "relaunch clears overflow", {31'b0, ovf_o}, 32'h0);
        run_to_done();
        chk(cyc_o == 16'd8, "R2", "relaunch count", {16'b0, cyc_o}, 32'h8);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule